// File: doc/BRIEF.md
# Interleaved Stride DMA Address Generator

This block produces the main-memory address sequence for a strided transfer between scratchpad and main memory. Once a transfer starts, it emits a number of consecutive quadword addresses as a burst. It then jumps over a gap of quadwords and starts the next burst. This repeats until the total quadword budget is used up. Each address is offered with a valid flag, and the consumer accepts it with a ready flag. One accepted beat moves one 16-byte quadword.

A start request is taken only in interleave mode and only while the block is idle. The burst length and gap are sampled when the transfer starts. A burst length of zero means the whole budget is sent as one burst. After every burst, the last one included, the address moves past the gap in a single cycle with no beat offered. A one-cycle done pulse then marks the end of the transfer. The data path and the scratchpad side are not part of this block. Only the address stepping and the quadword countdown are visible.

Top module: `ilv_addr_gen`

## Requirements
- R1: A start pulse is accepted only when the block is idle (busy_o low) and mode_i equals 2 (interleave). A start with another mode value, or a start while busy, has no effect on any output.
- R2: The cycle after an accepted start with a nonzero total count, busy_o and valid_o are high, addr_o equals the start address with its low 4 bits cleared, and qwc_o equals the total count.
- R3: Each cycle with valid_o and ready_i both high is one beat. On the next cycle, addr_o has increased by 16 and qwc_o has decreased by 1. While ready_i is low, addr_o, qwc_o and valid_o hold.
- R4: A burst ends after burst_len_i beats. The next cycle is a single gap cycle with valid_o low and busy_o high. After the gap cycle, addr_o has increased by gap_len_i × 16.
- R5: A burst also ends when qwc_o reaches zero, even if fewer than burst_len_i beats were sent. The gap is still added after this final burst.
- R6: A burst_len_i of zero at start makes the burst length equal to the total count. The whole transfer is then one burst followed by one gap.
- R7: done_o is high for exactly one cycle: the cycle after the final gap cycle. In that cycle busy_o is low, qwc_o is 0, and addr_o equals start + 16 × total + 16 × gap × (number of bursts).
- R8: burst_len_i and gap_len_i are sampled at start. Changing them during a transfer does not change the address sequence.
- R9: An accepted start with a total count of zero produces no beat. It gives a done_o pulse on the next cycle, and addr_o is left unchanged.
- R10: After reset, valid_o, busy_o and done_o are low, and addr_o and qwc_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| mode_i | input | 2 | Transfer mode; 2 selects interleave |
| addr_i | input | 32 | Main-memory start address |
| qwc_i | input | 16 | Total quadword count |
| burst_len_i | input | 10 | Quadwords per burst; 0 means the whole count |
| gap_len_i | input | 10 | Quadwords skipped after each burst |
| ready_i | input | 1 | Consumer accepts the current beat |
| addr_o | output | 32 | Current main-memory address |
| valid_o | output | 1 | Beat offered at addr_o |
| qwc_o | output | 16 | Quadwords remaining |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a final burst that ends because the count runs out partway through, while ready_i is also stalling. In that case the gap has to follow a short burst. A mistake there shows up only in the final address. The stimulus uses counts that are not multiples of the burst length, together with a periodic ready pattern that drops ready_i. It also changes the burst and gap inputs and sends an extra start in the middle of a transfer. This exposes any logic that reads the inputs after start.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SKIP} ilv_state_e;
  localparam logic [1:0] MODE_INTERLEAVE = 2'd2;
  localparam int unsigned QW_SHIFT = 4;
endpackage

// File: rtl/ilv_count_unit.sv
module ilv_count_unit #(
  parameter int unsigned CW = 16,
  parameter int unsigned SW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] qwc_i,
  input  logic [SW-1:0] tqwc_i,
  input  logic          beat_i,
  input  logic          rearm_i,
  output logic [CW-1:0] qwc_o,
  output logic          run_end_o,
  output logic          qwc_zero_o
);
  logic [CW-1:0] qwc_q, run_left_q, run_len_q, run_len_d;

  // zero burst length selects the full count
  assign run_len_d = (tqwc_i == '0) ? qwc_i : CW'(tqwc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qwc_q      <= '0;
      run_left_q <= '0;
      run_len_q  <= '0;
    end else if (load_i) begin
      qwc_q      <= qwc_i;
      run_left_q <= run_len_d;
      run_len_q  <= run_len_d;
    end else if (beat_i) begin
      qwc_q      <= qwc_q - 1'b1;
      run_left_q <= run_left_q - 1'b1;
    end else if (rearm_i) begin
      run_left_q <= run_len_q;
    end
  end

  assign qwc_o      = qwc_q;
  assign run_end_o  = (run_left_q == CW'(1)) || (qwc_q == CW'(1));
  assign qwc_zero_o = (qwc_q == '0);

  assert_beat_decrements_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |=> qwc_q == $past(qwc_q) - 1'b1);
  assert_run_within_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_left_q <= run_len_q);
endmodule

// File: rtl/ilv_addr_unit.sv
module ilv_addr_unit #(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] sqwc_i,
  input  logic          beat_i,
  input  logic          skip_i,
  output logic [AW-1:0] addr_o
);
  import ilv_pkg::*;
  localparam logic [AW-1:0] QW_BYTES = AW'(1) << QW_SHIFT;

  logic [AW-1:0] addr_q;
  logic [SW-1:0] sqwc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      sqwc_q <= '0;
    end else if (load_i) begin
      addr_q <= addr_i & ~(QW_BYTES - 1'b1);
      sqwc_q <= sqwc_i;
    end else if (beat_i) begin
      addr_q <= addr_q + QW_BYTES;
    end else if (skip_i) begin
      addr_q <= addr_q + (AW'(sqwc_q) << QW_SHIFT);
    end
  end

  assign addr_o = addr_q;

  assert_beat_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |=> addr_q == $past(addr_q) + QW_BYTES);
  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !beat_i && !skip_i |=> $stable(addr_q));
endmodule

// File: rtl/ilv_seq_fsm.sv
module ilv_seq_fsm (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  input  logic       qwc_in_zero_i,
  input  logic       ready_i,
  input  logic       run_end_i,
  input  logic       qwc_zero_i,
  output logic       load_o,
  output logic       beat_o,
  output logic       skip_o,
  output logic       rearm_o,
  output logic       valid_o,
  output logic       busy_o,
  output logic       done_o
);
  import ilv_pkg::*;
  ilv_state_e state_q, state_d;
  logic done_q, accept;

  assign accept  = (state_q == ST_IDLE) && start_i && (mode_i == MODE_INTERLEAVE);
  assign load_o  = accept && !qwc_in_zero_i;
  assign beat_o  = (state_q == ST_RUN) && ready_i;
  assign skip_o  = (state_q == ST_SKIP);
  assign rearm_o = skip_o && !qwc_zero_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_o) state_d = ST_RUN;
      ST_RUN:  if (beat_o && run_end_i) state_d = ST_SKIP;
      ST_SKIP: state_d = qwc_zero_i ? ST_IDLE : ST_RUN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (accept && qwc_in_zero_i) || (skip_o && qwc_zero_i);
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  assert_skip_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> !skip_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_stall_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o);
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter int unsigned SW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] qwc_i,
  input  logic [SW-1:0] burst_len_i,
  input  logic [SW-1:0] gap_len_i,
  input  logic          ready_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic [CW-1:0] qwc_o,
  output logic          busy_o,
  output logic          done_o
);
  logic load, beat, skip, rearm, run_end, qwc_zero;

  ilv_seq_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .mode_i,
    .qwc_in_zero_i(qwc_i == '0),
    .ready_i,
    .run_end_i(run_end),
    .qwc_zero_i(qwc_zero),
    .load_o(load), .beat_o(beat), .skip_o(skip), .rearm_o(rearm),
    .valid_o, .busy_o, .done_o
  );

  ilv_count_unit #(.CW(CW), .SW(SW)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(load), .qwc_i, .tqwc_i(burst_len_i),
    .beat_i(beat), .rearm_i(rearm),
    .qwc_o, .run_end_o(run_end), .qwc_zero_o(qwc_zero)
  );

  ilv_addr_unit #(.AW(AW), .SW(SW)) u_addr (
    .clk_i, .rst_ni,
    .load_i(load), .addr_i, .sqwc_i(gap_len_i),
    .beat_i(beat), .skip_i(skip),
    .addr_o
  );

  assert_done_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && qwc_o == '0);
  assert_valid_needs_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> busy_o && qwc_o != '0);
endmodule

// File: tb/sim_ilv_addr_gen.sv
`timescale 1ns/1ps
module sim_ilv_addr_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ready = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [31:0] addr_in = '0;
  logic [15:0] qwc_in = '0;
  logic [9:0] blen = '0, glen = '0;
  logic [31:0] addr_o;
  logic valid_o, busy_o, done_o;
  logic [15:0] qwc_o;

  int total = 0, bad = 0;
  string cur_req = "R10";

  // behavioural reference
  int ph = 0;
  longint r_addr = 0;
  int r_qwc = 0, r_left = 0, r_len = 0, r_gap = 0;
  bit r_done = 0;

  always #4 clk = ~clk;

  ilv_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .addr_i(addr_in), .qwc_i(qwc_in), .burst_len_i(blen), .gap_len_i(glen),
    .ready_i(ready), .addr_o(addr_o), .valid_o(valid_o), .qwc_o(qwc_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; r_addr = 0; r_qwc = 0; r_left = 0; r_len = 0; r_gap = 0; r_done = 0;
    end else begin
      r_done = 0;
      if (ph == 0) begin
        if (start && mode == 2'd2) begin
          if (qwc_in == 0) r_done = 1;
          else begin
            ph = 1; r_addr = addr_in & 32'hFFFF_FFF0; r_qwc = qwc_in;
            r_len = (blen == 0) ? int'(qwc_in) : int'(blen);
            r_left = r_len; r_gap = glen;
          end
        end
      end else if (ph == 1) begin
        if (ready) begin
          r_addr = (r_addr + 16) & 32'hFFFF_FFFF; r_qwc--; r_left--;
          if (r_left == 0 || r_qwc == 0) ph = 2;
        end
      end else begin
        r_addr = (r_addr + 16 * r_gap) & 32'hFFFF_FFFF;
        if (r_qwc == 0) begin ph = 0; r_done = 1; end
        else begin ph = 1; r_left = r_len; end
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n) begin
    check(cur_req, "addr_o", addr_o, r_addr);
    check(cur_req, "valid_o", valid_o, ph == 1);
    check(cur_req, "busy_o", busy_o, ph != 0);
    check(cur_req, "qwc_o", qwc_o, r_qwc);
    check(cur_req, "done_o", done_o, r_done);
  end

  task automatic run_xfer(input int a, input int q, input int t, input int s,
                          input bit stall, input bit alt, input string req);
    int beats = 0, cyc = 0, teff, runs;
    longint base, exp_addr;
    bit seen = 0;
    cur_req = req;
    base = (q == 0) ? longint'(addr_o) : longint'(a & 32'hFFFF_FFF0);
    @(negedge clk);
    start = 1; mode = 2'd2; addr_in = a; qwc_in = q; blen = t; glen = s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      start = 0;
      if (alt) begin
        blen = 10'h3FF - blen; glen = glen + 7;
        if (i == 2) begin start = 1; addr_in = 32'h0BAD_0000; qwc_in = 3; end
      end
      if (done_o) begin seen = 1; break; end
      ready = stall ? ((cyc % 3) != 1) : 1'b1;
      cyc++;
      if (valid_o && ready) beats++;
    end
    start = 0; ready = 0;
    teff = (t == 0) ? q : t;
    runs = (q == 0) ? 0 : (q + teff - 1) / teff;
    exp_addr = (base + 16 * q + 16 * s * runs) & 32'hFFFF_FFFF;
    check(req, "done seen", seen, 1);
    check(req, "beat count", beats, q);
    check("R7", "final addr", addr_o, exp_addr);
    check("R7", "busy at done", busy_o, 0);
    check("R7", "qwc at done", qwc_o, 0);
    @(negedge clk);
    check("R7", "done width", done_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset valid", valid_o, 0);
    check("R10", "reset busy", busy_o, 0);
    check("R10", "reset done", done_o, 0);
    check("R10", "reset addr", addr_o, 0);
    check("R10", "reset qwc", qwc_o, 0);
    rst_n = 1;
    // R1: wrong mode ignored
    cur_req = "R1";
    @(negedge clk);
    start = 1; mode = 2'd1; addr_in = 32'h100; qwc_in = 4; blen = 2; glen = 1;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    check("R1", "busy after bad mode", busy_o, 0);
    check("R1", "valid after bad mode", valid_o, 0);
    // R2 checked per cycle in each transfer; R4/R5: partial final burst
    run_xfer(32'h0000_1008, 10, 3, 2, 0, 0, "R5");
    run_xfer(32'h0000_2000, 7, 0, 5, 0, 0, "R6");
    run_xfer(32'h0000_3000, 8, 4, 1, 1, 0, "R3");
    run_xfer(32'h0000_4000, 0, 2, 3, 0, 0, "R9");
    run_xfer(32'h0000_5000, 6, 2, 3, 1, 1, "R8");
    run_xfer(32'h0000_6000, 5, 5, 0, 0, 0, "R4");
    run_xfer(32'h0000_7000, 9, 2, 4, 1, 0, "R2");
    // R9: zero count leaves address unchanged
    run_xfer(32'h0000_8000, 0, 0, 0, 1, 0, "R9");
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule